// File: doc/BRIEF.md
# Shared-Bus Three-Register Transfer Datapath

This block holds three general registers of parameterised width that exchange data over one internal bus. In each cycle the bus carries a single value: either one register's contents or an external data word. Any subset of the three registers may capture that value at the next rising clock edge. A register that is not loaded keeps its contents through a hold multiplexer in front of its flip-flops. The clock is never gated.

The bus source can be picked in two ways, and a mode input chooses between them. In encoded mode a 2-bit code selects R0, R1, R2 or the external input. In one-hot mode there is one drive enable per register and the bus is the OR of the enabled sources. If no enable is set, the bus reads zero. If two or more enables are set, a conflict flag rises and every load in that cycle is suppressed. All destinations loaded in one cycle receive the same word, so a group of transfers that need different sources takes one cycle per distinct source.

Top module: `bus_xfer_dp`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, all three registers become zero at that edge.
- R2: In encoded mode (`drv_mode`=0), `bus_sel` codes 0, 1 and 2 put R0, R1 and R2 respectively on `bus_val` in the same cycle.
- R3: In encoded mode, `bus_sel` code 3 puts `ext_din` on `bus_val`.
- R4: A register whose bit in `ld_en` is 1 (bit 0 = R0, bit 1 = R1, bit 2 = R2) takes the `bus_val` of that cycle at the next rising edge, unless a conflict is flagged.
- R5: A register whose `ld_en` bit is 0 keeps its value across the edge.
- R6: When several `ld_en` bits are set in one cycle, every loaded register receives the same bus word.
- R7: A register that is both the bus source and a destination in one cycle ends with its own previous value, and the other destinations get that pre-edge value.
- R8: In one-hot mode (`drv_mode`=1), a single set bit in `drv_en` (bit i = Ri) puts that register on `bus_val`.
- R9: In one-hot mode with `drv_en`=0, `bus_val` is zero and loaded registers become zero.
- R10: In one-hot mode with two or more `drv_en` bits set, `drv_conflict` is 1 in that cycle and no register changes at the following edge.
- R11: In encoded mode, `drv_conflict` is 0 whatever `drv_en` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| drv_mode | input | 1 | 0 = encoded source code, 1 = one-hot drive enables |
| bus_sel | input | 2 | Encoded source: 0 R0, 1 R1, 2 R2, 3 external |
| drv_en | input | 3 | One-hot drive enables, bit i drives Ri |
| ld_en | input | 3 | Load enables, bit i loads Ri |
| ext_din | input | W | External data word |
| r0_q | output | W | Contents of R0 |
| r1_q | output | W | Contents of R1 |
| r2_q | output | W | Contents of R2 |
| bus_val | output | W | Current bus value |
| drv_conflict | output | 1 | More than one one-hot enable is active |

## Verification
A register can be the bus source and a load destination in the same cycle. The random mix sets source and destination bits independently, and a directed cycle makes R0 the source while all three registers load. The bench judges this case by checking that the source keeps its old value and that the other registers get that pre-edge word, not the value after the update. A second overlap is a driver conflict that arrives together with load requests. The bench sets all enables while all loads are high and checks both that the flag rises and that every register keeps its value.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;

    localparam int NUM_REGS = 3;
    localparam int SEL_W    = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_R0  = 2'd0,
        SRC_R1  = 2'd1,
        SRC_R2  = 2'd2,
        SRC_EXT = 2'd3
    } src_sel_e;

    typedef enum logic {
        DRV_ENCODED = 1'b0,
        DRV_ONEHOT  = 1'b1
    } drv_mode_e;

    typedef struct packed {
        drv_mode_e             mode;
        src_sel_e              sel;
        logic [NUM_REGS-1:0]   drv;
        logic [NUM_REGS-1:0]   ld;
    } xfer_ctrl_t;

    // True when two or more bits of the enable vector are set.
    function automatic logic multi_hot(input logic [NUM_REGS-1:0] v);
        int cnt;
        cnt = 0;
        for (int i = 0; i < NUM_REGS; i++) begin
            cnt = cnt + int'(v[i]);
        end
        return (cnt > 1);
    endfunction

endpackage

// File: rtl/bus_src_sel.sv
module bus_src_sel
    import bus_xfer_pkg::*;
#(
    parameter int W = 8
) (
    input  xfer_ctrl_t                ctrl,
    input  logic [W-1:0]              ext,
    input  logic [NUM_REGS*W-1:0]     regs_flat,
    output logic [W-1:0]              bus,
    output logic                      conflict
);

    logic [W-1:0] enc_bus;
    logic [W-1:0] oh_terms [NUM_REGS];
    logic [W-1:0] oh_bus;

    always_comb begin
        unique case (ctrl.sel)
            SRC_R0:  enc_bus = regs_flat[0*W +: W];
            SRC_R1:  enc_bus = regs_flat[1*W +: W];
            SRC_R2:  enc_bus = regs_flat[2*W +: W];
            default: enc_bus = ext;
        endcase
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_oh_term
            assign oh_terms[g] = regs_flat[g*W +: W] & {W{ctrl.drv[g]}};
        end
    endgenerate

    always_comb begin
        oh_bus = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            oh_bus = oh_bus | oh_terms[i];
        end
    end

    assign bus      = (ctrl.mode == DRV_ONEHOT) ? oh_bus : enc_bus;
    assign conflict = (ctrl.mode == DRV_ONEHOT) && multi_hot(ctrl.drv);

endmodule

// File: rtl/bus_load_gate.sv
module bus_load_gate
    import bus_xfer_pkg::*;
(
    input  logic [NUM_REGS-1:0] ld_req,
    input  logic                conflict,
    output logic [NUM_REGS-1:0] ld_eff
);

    assign ld_eff = conflict ? '0 : ld_req;

endmodule

// File: rtl/bus_reg_cell.sv
module bus_reg_cell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] nxt;

    // Hold path: the register's own output is fed back when not loading.
    always_comb begin
        nxt = load ? d : q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/bus_xfer_dp.sv
module bus_xfer_dp
    import bus_xfer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                drv_mode,
    input  logic [SEL_W-1:0]    bus_sel,
    input  logic [NUM_REGS-1:0] drv_en,
    input  logic [NUM_REGS-1:0] ld_en,
    input  logic [W-1:0]        ext_din,
    output logic [W-1:0]        r0_q,
    output logic [W-1:0]        r1_q,
    output logic [W-1:0]        r2_q,
    output logic [W-1:0]        bus_val,
    output logic                drv_conflict
);

    localparam int FLAT_W = NUM_REGS * W;

    xfer_ctrl_t          ctrl;
    logic [FLAT_W-1:0]   regs_flat;
    logic [NUM_REGS-1:0] ld_eff;
    logic [W-1:0]        bus_w;
    logic                conflict_w;

    always_comb begin
        ctrl.mode = drv_mode_e'(drv_mode);
        ctrl.sel  = src_sel_e'(bus_sel);
        ctrl.drv  = drv_en;
        ctrl.ld   = ld_en;
    end

    bus_src_sel #(.W(W)) u_src (
        .ctrl      (ctrl),
        .ext       (ext_din),
        .regs_flat (regs_flat),
        .bus       (bus_w),
        .conflict  (conflict_w)
    );

    bus_load_gate u_gate (
        .ld_req   (ctrl.ld),
        .conflict (conflict_w),
        .ld_eff   (ld_eff)
    );

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [W-1:0] q_w;
            bus_reg_cell #(.W(W)) u_cell (
                .clk  (clk),
                .rst  (rst),
                .load (ld_eff[g]),
                .d    (bus_w),
                .q    (q_w)
            );
            assign regs_flat[g*W +: W] = q_w;
        end
    endgenerate

    assign r0_q         = regs_flat[0*W +: W];
    assign r1_q         = regs_flat[1*W +: W];
    assign r2_q         = regs_flat[2*W +: W];
    assign bus_val      = bus_w;
    assign drv_conflict = conflict_w;

endmodule

// File: rtl/bus_xfer_chk.sv
module bus_xfer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         drv_mode,
    input logic [1:0]   bus_sel,
    input logic [2:0]   drv_en,
    input logic [2:0]   ld_en,
    input logic [W-1:0] ext_din,
    input logic [W-1:0] r0_q,
    input logic [W-1:0] r1_q,
    input logic [W-1:0] r2_q,
    input logic [W-1:0] bus_val,
    input logic         drv_conflict
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (r0_q == '0 && r1_q == '0 && r2_q == '0)); // R1

    AST_SEL_R1_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!drv_mode && bus_sel == 2'd1) |-> bus_val == r1_q); // R2

    AST_SEL_EXT_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!drv_mode && bus_sel == 2'd3) |-> bus_val == ext_din); // R3

    AST_LOAD_R0: assert property (@(posedge clk) disable iff (rst)
        (ld_en[0] && !drv_conflict) |=> r0_q == $past(bus_val)); // R4
    AST_LOAD_R1: assert property (@(posedge clk) disable iff (rst)
        (ld_en[1] && !drv_conflict) |=> r1_q == $past(bus_val)); // R4
    AST_LOAD_R2: assert property (@(posedge clk) disable iff (rst)
        (ld_en[2] && !drv_conflict) |=> r2_q == $past(bus_val)); // R4

    AST_HOLD_R0: assert property (@(posedge clk) disable iff (rst)
        !ld_en[0] |=> $stable(r0_q)); // R5
    AST_HOLD_R1: assert property (@(posedge clk) disable iff (rst)
        !ld_en[1] |=> $stable(r1_q)); // R5
    AST_HOLD_R2: assert property (@(posedge clk) disable iff (rst)
        !ld_en[2] |=> $stable(r2_q)); // R5

    AST_ONEHOT_R1: assert property (@(posedge clk) disable iff (rst)
        (drv_mode && drv_en == 3'b010) |-> bus_val == r1_q); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (drv_mode && drv_en == 3'b000) |-> bus_val == '0); // R9

    AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (drv_mode && $countones(drv_en) > 1) |-> drv_conflict); // R10

    AST_CONFLICT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        drv_conflict |=> ($stable(r0_q) && $stable(r1_q) && $stable(r2_q))); // R10

    AST_ENCODED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        !drv_mode |-> !drv_conflict); // R11

endmodule

bind bus_xfer_dp bus_xfer_chk #(.W(W)) u_chk (.*);

// File: tb/bus_xfer_dp_tb.sv
module bus_xfer_dp_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         drv_mode = 1'b0;
    logic [1:0]   bus_sel = 2'd0;
    logic [2:0]   drv_en = 3'd0;
    logic [2:0]   ld_en = 3'd0;
    logic [W-1:0] ext_din = '0;
    logic [W-1:0] r0_q, r1_q, r2_q, bus_val;
    logic         drv_conflict;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [W-1:0] m [3];

    always #10 clk = ~clk;

    bus_xfer_dp #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .drv_mode(drv_mode), .bus_sel(bus_sel),
        .drv_en(drv_en), .ld_en(ld_en), .ext_din(ext_din),
        .r0_q(r0_q), .r1_q(r1_q), .r2_q(r2_q), .bus_val(bus_val),
        .drv_conflict(drv_conflict)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ones3(input logic [2:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]);
    endfunction

    function automatic logic exp_conflict();
        return drv_mode && (ones3(drv_en) > 1);
    endfunction

    function automatic logic [W-1:0] exp_bus();
        logic [W-1:0] b;
        if (!drv_mode) begin
            b = (bus_sel == 2'd3) ? ext_din : m[bus_sel];
        end else begin
            b = '0;
            for (int i = 0; i < 3; i++) if (drv_en[i]) b = b | m[i];
        end
        return b;
    endfunction

    function automatic logic [W-1:0] reg_out(input int i);
        return (i == 0) ? r0_q : (i == 1) ? r1_q : r2_q;
    endfunction

    // Inputs are already driven (after a falling edge); check bus, clock once, check registers.
    task automatic step();
        logic [W-1:0] eb;
        logic ec;
        int src;
        string tb_tag;
        #2;
        eb = exp_bus();
        ec = exp_conflict();
        if (!drv_mode) begin
            chk("R11 conflict flag", W'(drv_conflict), W'(1'b0));
            chk(bus_sel == 2'd3 ? "R3 ext on bus" : "R2 reg on bus", bus_val, eb);
        end else begin
            chk("R10 conflict flag", W'(drv_conflict), W'(ec));
            if (!ec) chk(drv_en == 3'd0 ? "R9 idle bus zero" : "R8 one-hot bus", bus_val, eb);
        end
        src = drv_mode ? (drv_en == 3'b001 ? 0 : drv_en == 3'b010 ? 1 : drv_en == 3'b100 ? 2 : -1)
                       : (bus_sel == 2'd3 ? -1 : int'(bus_sel));
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            if (ec) tb_tag = "R10 no load on conflict";
            else if (!ld_en[i]) tb_tag = "R5 hold";
            else if (i == src) tb_tag = "R7 source reloads own value";
            else if (ones3(ld_en) > 1) tb_tag = "R6 broadcast load";
            else tb_tag = "R4 load";
            if (!ec && ld_en[i]) m[i] = eb;
            chk(tb_tag, reg_out(i), m[i]);
        end
    endtask

    task automatic drive(input logic md, input logic [1:0] s, input logic [2:0] e,
                         input logic [2:0] l, input logic [W-1:0] x);
        drv_mode = md; bus_sel = s; drv_en = e; ld_en = l; ext_din = x;
        step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ld_en = 3'b111; drv_mode = 1'b0; bus_sel = 2'd3; ext_din = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            m[i] = '0;
            chk("R1 reset clears", reg_out(i), '0);
        end
        rst = 1'b0;
        ld_en = 3'b000;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) m[i] = '0;
        @(negedge clk);
        do_reset();
        // R3: initialise from the external input, one destination per cycle
        drive(1'b0, 2'd3, 3'b000, 3'b001, 8'hA5);
        drive(1'b0, 2'd3, 3'b000, 3'b010, 8'h3C);
        drive(1'b0, 2'd3, 3'b000, 3'b100, 8'h0F);
        // R2: each register as source, idle loads (R5)
        drive(1'b0, 2'd0, 3'b000, 3'b000, 8'h00);
        drive(1'b0, 2'd1, 3'b000, 3'b000, 8'h00);
        drive(1'b0, 2'd2, 3'b000, 3'b000, 8'h00);
        // R7: R0 is source and every register loads it
        drive(1'b0, 2'd0, 3'b000, 3'b111, 8'h00);
        // R6: broadcast external word to two destinations
        drive(1'b0, 2'd3, 3'b000, 3'b011, 8'h5A);
        // R8: one-hot single driver
        drive(1'b1, 2'd0, 3'b010, 3'b100, 8'h00);
        // R10: all enables with all loads requested
        drive(1'b1, 2'd0, 3'b111, 3'b111, 8'h00);
        drive(1'b1, 2'd0, 3'b101, 3'b010, 8'h00);
        // R9: no enable, R2 loaded with zero
        drive(1'b1, 2'd0, 3'b000, 3'b100, 8'h00);
        // R11: encoded mode ignores drive enables
        drive(1'b0, 2'd1, 3'b111, 3'b100, 8'h00);
        // Random mix
        for (int n = 0; n < 600; n++) begin
            drive(($urandom % 4) == 0, 2'($urandom), 3'($urandom), 3'($urandom), W'($urandom));
        end
        // R1: reset again from non-zero state
        do_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule